// File: doc/BRIEF.md
# Tagged Word Store for Producer-Consumer Handoff

This block is a small register-based memory in which every word has a one-bit occupancy tag that says whether the word holds data nobody has consumed yet. A producer deposits a word with a "put". The put is accepted only while the word is vacant, and it marks the word occupied. A consumer removes the word with a "take". The take is accepted only while the word is occupied, and it marks the word vacant again. The data access and the tag update are committed together on one clock edge, so no other request can see one without the other.

Two request ports share the store. Each request is answered combinationally in the cycle it is presented, with an accept flag or a retry flag. A refused request changes nothing, and the requester presents it again later. Plain reads and writes bypass the tag entirely. A clear operation vacates every word at once. When both ports touch the same word in one cycle, or when either of them clears, port 0 is served and port 1 is refused.

Top module: `fe_tagmem`

## Requirements
- R1: After reset every tag is vacant and every data word reads as zero. A take to any address returns retry.
- R2: A put (op code 3) to a vacant word is accepted in the same cycle. It stores the write data and marks the word occupied from the next cycle.
- R3: A put to an occupied word returns retry and leaves both data and tag unchanged.
- R4: A take (op code 4) to an occupied word is accepted in the same cycle. It returns the stored data on rdata and marks the word vacant from the next cycle.
- R5: A take to a vacant word returns retry, drives rdata to zero and changes nothing.
- R6: A plain read (op code 1) is always accepted, returns the stored data whatever the tag, and leaves the tag as it was.
- R7: A plain write (op code 2) is always accepted, replaces the data and leaves the tag as it was.
- R8: A clear (op code 5) is accepted, vacates every tag in the next cycle and keeps all data.
- R9: When both ports present active operations to the same address in one cycle, port 0 is handled normally and port 1 gets retry with no effect.
- R10: A clear on port 0 refuses any active port-1 request in that cycle. A clear on port 1 is refused whenever port 0 is active, and is accepted when port 0 is idle.
- R11: Active requests to different addresses on the two ports are both served in the same cycle.
- R12: An idle port, or an op code of 0, 6 or 7, gets neither accept nor retry, and rdata is zero. Accept and retry are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_valid | input | 1 | Port 0 request present |
| p0_op | input | 3 | Port 0 operation code |
| p0_addr | input | AW | Port 0 word address |
| p0_wdata | input | DW | Port 0 write data |
| p0_ok | output | 1 | Port 0 request accepted |
| p0_retry | output | 1 | Port 0 request refused, present again |
| p0_rdata | output | DW | Port 0 read data (accepted read or take only) |
| p1_valid | input | 1 | Port 1 request present |
| p1_op | input | 3 | Port 1 operation code |
| p1_addr | input | AW | Port 1 word address |
| p1_wdata | input | DW | Port 1 write data |
| p1_ok | output | 1 | Port 1 request accepted |
| p1_retry | output | 1 | Port 1 request refused, present again |
| p1_rdata | output | DW | Port 1 read data (accepted read or take only) |

## Verification
Two functions can land in one cycle. The first is a port-0 access and a port-1 access aimed at the same word, for example a put racing a put or a take racing a read. The second is a clear on either port alongside any activity on the other. Directed cycles set up each of these collisions explicitly. A long random phase then keeps addresses in a narrow range so that collisions happen often. A reference model of tags and data in the bench predicts the accept, retry and read data of both ports every cycle. It also predicts what a later take reveals, which shows whether the refused port left any trace behind.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_RD    = 3'd1,
        OP_WR    = 3'd2,
        OP_PUT   = 3'd3,
        OP_TAKE  = 3'd4,
        OP_CLEAR = 3'd5
    } fe_op_e;

    localparam int NPORTS = 2;

    // Decision for one port in one cycle
    typedef struct packed {
        logic ok;
        logic retry;
        logic data_we;
        logic tag_we;
        logic tag_val;
        logic clear_all;
    } fe_act_t;

    function automatic logic op_active(input logic [2:0] op);
        return (op >= 3'd1) && (op <= 3'd5);
    endfunction

endpackage

// File: rtl/fe_port_eval.sv
module fe_port_eval
    import fe_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          valid,
    input  logic [2:0]    op,
    input  logic          blocked,
    input  logic          cur_tag,
    input  logic [DW-1:0] cur_data,
    output fe_act_t       act,
    output logic [DW-1:0] rdata
);

    always_comb begin
        act   = '0;
        rdata = '0;
        if (valid && op_active(op)) begin
            if (blocked) begin
                act.retry = 1'b1;
            end else begin
                unique case (op)
                    OP_RD: begin
                        act.ok = 1'b1;
                        rdata  = cur_data;
                    end
                    OP_WR: begin
                        act.ok      = 1'b1;
                        act.data_we = 1'b1;
                    end
                    OP_PUT: begin
                        if (cur_tag) begin
                            act.retry = 1'b1;
                        end else begin
                            act.ok      = 1'b1;
                            act.data_we = 1'b1;
                            act.tag_we  = 1'b1;
                            act.tag_val = 1'b1;
                        end
                    end
                    OP_TAKE: begin
                        if (cur_tag) begin
                            act.ok      = 1'b1;
                            act.tag_we  = 1'b1;
                            act.tag_val = 1'b0;
                            rdata       = cur_data;
                        end else begin
                            act.retry = 1'b1;
                        end
                    end
                    OP_CLEAR: begin
                        act.ok        = 1'b1;
                        act.clear_all = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/fe_arbiter.sv
module fe_arbiter
    import fe_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          v0,
    input  logic [2:0]    op0,
    input  logic [AW-1:0] a0,
    input  logic          v1,
    input  logic [2:0]    op1,
    input  logic [AW-1:0] a1,
    output logic [NPORTS-1:0] blocked
);

    logic act0, act1, clear_any;

    always_comb begin
        act0       = v0 && op_active(op0);
        act1       = v1 && op_active(op1);
        clear_any  = (op0 == OP_CLEAR) || (op1 == OP_CLEAR);
        blocked[0] = 1'b0;
        blocked[1] = act0 && act1 && (clear_any || (a0 == a1));
    end

endmodule

// File: rtl/fe_store.sv
module fe_store
    import fe_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr    [NPORTS],
    input  logic [DW-1:0] wdata   [NPORTS],
    input  logic          data_we [NPORTS],
    input  logic          tag_we  [NPORTS],
    input  logic          tag_val [NPORTS],
    input  logic          clear_all,
    output logic [DW-1:0] rd_data [NPORTS],
    output logic          rd_tag  [NPORTS]
);

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] tags;

    always_ff @(posedge clk) begin
        if (rst) begin
            tags <= '0;
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else begin
            for (int p = 0; p < NPORTS; p++) begin
                if (data_we[p]) mem[addr[p]] <= wdata[p];
            end
            if (clear_all) begin
                tags <= '0;
            end else begin
                for (int p = 0; p < NPORTS; p++) begin
                    if (tag_we[p]) tags[addr[p]] <= tag_val[p];
                end
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        assign rd_data[p] = mem[addr[p]];
        assign rd_tag[p]  = tags[addr[p]];
    end

endmodule

// File: rtl/fe_tagmem.sv
module fe_tagmem
    import fe_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          p0_valid,
    input  logic [2:0]    p0_op,
    input  logic [AW-1:0] p0_addr,
    input  logic [DW-1:0] p0_wdata,
    output logic          p0_ok,
    output logic          p0_retry,
    output logic [DW-1:0] p0_rdata,
    input  logic          p1_valid,
    input  logic [2:0]    p1_op,
    input  logic [AW-1:0] p1_addr,
    input  logic [DW-1:0] p1_wdata,
    output logic          p1_ok,
    output logic          p1_retry,
    output logic [DW-1:0] p1_rdata
);

    logic              vld   [NPORTS];
    logic [2:0]        opc   [NPORTS];
    logic [AW-1:0]     adr   [NPORTS];
    logic [DW-1:0]     wd    [NPORTS];
    logic [DW-1:0]     rd    [NPORTS];
    logic [DW-1:0]     cur_d [NPORTS];
    logic              cur_t [NPORTS];
    logic              d_we  [NPORTS];
    logic              t_we  [NPORTS];
    logic              t_val [NPORTS];
    fe_act_t           act   [NPORTS];
    logic [NPORTS-1:0] blk;
    logic              clr;

    assign vld[0] = p0_valid;  assign vld[1] = p1_valid;
    assign opc[0] = p0_op;     assign opc[1] = p1_op;
    assign adr[0] = p0_addr;   assign adr[1] = p1_addr;
    assign wd[0]  = p0_wdata;  assign wd[1]  = p1_wdata;

    fe_arbiter #(.AW(AW)) u_arb (
        .v0(p0_valid), .op0(p0_op), .a0(p0_addr),
        .v1(p1_valid), .op1(p1_op), .a1(p1_addr),
        .blocked(blk)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        fe_port_eval #(.DW(DW)) u_eval (
            .valid(vld[p]), .op(opc[p]), .blocked(blk[p]),
            .cur_tag(cur_t[p]), .cur_data(cur_d[p]),
            .act(act[p]), .rdata(rd[p])
        );
        assign d_we[p]  = act[p].data_we;
        assign t_we[p]  = act[p].tag_we;
        assign t_val[p] = act[p].tag_val;
    end

    assign clr = act[0].clear_all || act[1].clear_all;

    fe_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .addr(adr), .wdata(wd),
        .data_we(d_we), .tag_we(t_we), .tag_val(t_val),
        .clear_all(clr), .rd_data(cur_d), .rd_tag(cur_t)
    );

    assign p0_ok    = act[0].ok;
    assign p0_retry = act[0].retry;
    assign p0_rdata = rd[0];
    assign p1_ok    = act[1].ok;
    assign p1_retry = act[1].retry;
    assign p1_rdata = rd[1];

endmodule

// File: rtl/fe_tagmem_chk.sv
module fe_tagmem_chk
    import fe_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          p0_valid,
    input logic [2:0]    p0_op,
    input logic [AW-1:0] p0_addr,
    input logic [DW-1:0] p0_wdata,
    input logic          p0_ok,
    input logic          p0_retry,
    input logic [DW-1:0] p0_rdata,
    input logic          p1_valid,
    input logic [2:0]    p1_op,
    input logic [AW-1:0] p1_addr,
    input logic [DW-1:0] p1_wdata,
    input logic          p1_ok,
    input logic          p1_retry,
    input logic [DW-1:0] p1_rdata
);

    logic          prv_put_ok, prv_take_ok;
    logic [AW-1:0] prv_addr;
    logic [DW-1:0] prv_data;
    logic          act0, act1, p0_take, p0_put;

    assign act0    = p0_valid && op_active(p0_op);
    assign act1    = p1_valid && op_active(p1_op);
    assign p0_take = p0_valid && (p0_op == OP_TAKE);
    assign p0_put  = p0_valid && (p0_op == OP_PUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            prv_put_ok  <= 1'b0;
            prv_take_ok <= 1'b0;
            prv_addr    <= '0;
            prv_data    <= '0;
        end else begin
            prv_put_ok  <= p0_put  && p0_ok && !p1_valid;
            prv_take_ok <= p0_take && p0_ok && !p1_valid;
            prv_addr    <= p0_addr;
            prv_data    <= p0_wdata;
        end
    end

    a_r12_p0_excl: assert property (@(posedge clk) disable iff (rst)
        !(p0_ok && p0_retry));
    a_r12_p1_excl: assert property (@(posedge clk) disable iff (rst)
        !(p1_ok && p1_retry));
    a_r2_put_then_take: assert property (@(posedge clk) disable iff (rst)
        (prv_put_ok && p0_take && p0_addr == prv_addr) |-> (p0_ok && p0_rdata == prv_data));
    a_r3_put_on_full: assert property (@(posedge clk) disable iff (rst)
        (prv_put_ok && p0_put && p0_addr == prv_addr) |-> p0_retry);
    a_r4_take_then_empty: assert property (@(posedge clk) disable iff (rst)
        (prv_take_ok && p0_take && p0_addr == prv_addr) |-> p0_retry);
    a_r9_same_word: assert property (@(posedge clk) disable iff (rst)
        (act0 && act1 && p0_addr == p1_addr) |-> (p1_retry && !p1_ok));
    a_r10_clear_blocks: assert property (@(posedge clk) disable iff (rst)
        (p0_valid && p0_op == OP_CLEAR && act1) |-> p1_retry);

endmodule

bind fe_tagmem fe_tagmem_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/fe_tagmem_tb.sv
module fe_tagmem_tb;

    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          p0_valid = 0, p1_valid = 0;
    logic [2:0]    p0_op = 0, p1_op = 0;
    logic [AW-1:0] p0_addr = 0, p1_addr = 0;
    logic [DW-1:0] p0_wdata = 0, p1_wdata = 0;
    logic          p0_ok, p0_retry, p1_ok, p1_retry;
    logic [DW-1:0] p0_rdata, p1_rdata;

    always #10 clk = ~clk;

    fe_tagmem #(.DW(DW), .DEPTH(DEPTH)) u_dut (.*);

    typedef struct {
        int          port;
        bit          ok;
        bit          retry;
        logic [DW-1:0] rdata;
        string       req;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_tag [DEPTH];
    int            n_checks = 0;
    int            n_fail = 0;
    bit            done = 0;

    function automatic bit is_act(bit v, logic [2:0] op);
        return v && op >= 1 && op <= 5;
    endfunction

    // Expected response from pre-cycle model state
    function automatic exp_t predict(int port, bit v, logic [2:0] op, logic [AW-1:0] a,
                                     bit blocked, string req);
        exp_t e;
        e.port = port; e.ok = 0; e.retry = 0; e.rdata = '0; e.req = req;
        if (is_act(v, op)) begin
            if (blocked) e.retry = 1;
            else case (op)
                3'd1: begin e.ok = 1; e.rdata = m_mem[a]; end
                3'd2, 3'd5: e.ok = 1;
                3'd3: if (m_tag[a]) e.retry = 1; else e.ok = 1;
                3'd4: if (m_tag[a]) begin e.ok = 1; e.rdata = m_mem[a]; end
                      else e.retry = 1;
                default: ;
            endcase
        end
        return e;
    endfunction

    function automatic void commit(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d, bit ok);
        if (!ok) return;
        case (op)
            3'd2: m_mem[a] = d;
            3'd3: begin m_mem[a] = d; m_tag[a] = 1; end
            3'd4: m_tag[a] = 0;
            3'd5: for (int w = 0; w < DEPTH; w++) m_tag[w] = 0;
            default: ;
        endcase
    endfunction

    task automatic apply(bit v0, logic [2:0] o0, logic [AW-1:0] a0, logic [DW-1:0] d0,
                         bit v1, logic [2:0] o1, logic [AW-1:0] a1, logic [DW-1:0] d1,
                         string req);
        exp_t e0, e1;
        bit blk1;
        @(posedge clk); #2;
        p0_valid = v0; p0_op = o0; p0_addr = a0; p0_wdata = d0;
        p1_valid = v1; p1_op = o1; p1_addr = a1; p1_wdata = d1;
        blk1 = is_act(v0, o0) && is_act(v1, o1) && (o0 == 5 || o1 == 5 || a0 == a1);
        e0 = predict(0, v0, o0, a0, 0, req);
        e1 = predict(1, v1, o1, a1, blk1, req);
        sb.push_back(e0);
        sb.push_back(e1);
        if (!rst) begin
            commit(o0, a0, d0, e0.ok);
            commit(o1, a1, d1, e1.ok);
        end
    endtask

    task automatic idle(string req);
        apply(0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    // Monitor: compare at the falling edge, mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                bit aok, art;
                logic [DW-1:0] ard;
                e = sb.pop_front();
                aok = (e.port == 0) ? p0_ok : p1_ok;
                art = (e.port == 0) ? p0_retry : p1_retry;
                ard = (e.port == 0) ? p0_rdata : p1_rdata;
                n_checks++;
                if (aok !== e.ok || art !== e.retry || ard !== e.rdata) begin
                    n_fail++;
                    $display("FAIL %s port%0d: ok/retry/rdata actual %b/%b/%h expected %b/%b/%h",
                             e.req, e.port, aok, art, ard, e.ok, e.retry, e.rdata);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < DEPTH; w++) begin m_mem[w] = '0; m_tag[w] = 0; end
        repeat (3) idle("R12");
        @(posedge clk); #1 rst = 1'b0;

        // R1: everything vacant and zero after reset
        for (int w = 0; w < DEPTH; w++) apply(1, 4, w[AW-1:0], 0, 1, 1, AW'(DEPTH-1-w), 0, "R1");

        // R2, R11: puts on both ports at different words
        apply(1, 3, 3, 32'hA5A5_0003, 1, 3, 7, 32'h7777_0007, "R11");
        // R3: put on occupied word refused; data unchanged
        apply(1, 3, 3, 32'hDEAD_BEEF, 0, 0, 0, 0, "R3");
        apply(1, 1, 3, 0, 0, 0, 0, 0, "R3");
        // R6: plain read keeps tag, then take succeeds (R4)
        apply(0, 0, 0, 0, 1, 1, 3, 0, "R6");
        apply(1, 4, 3, 0, 0, 0, 0, 0, "R4");
        // R5: take of now vacant word
        apply(1, 4, 3, 0, 0, 0, 0, 0, "R5");
        // R7: plain write keeps vacant tag / occupied tag
        apply(1, 2, 3, 32'h0BAD_F00D, 1, 2, 7, 32'h1234_5678, "R7");
        apply(1, 4, 3, 0, 1, 4, 7, 0, "R7");
        apply(1, 1, 3, 0, 0, 0, 0, 0, "R7");

        // R9: same-word races
        apply(1, 3, 5, 32'h5555_AAAA, 1, 3, 5, 32'hFFFF_0000, "R9");
        apply(1, 1, 5, 0, 1, 4, 5, 0, "R9");
        apply(0, 0, 0, 0, 1, 4, 5, 0, "R9");

        // R8, R10: clear on port 0 refuses port 1
        apply(1, 3, 9, 32'h9999_0009, 1, 3, 10, 32'hAAAA_000A, "R8");
        apply(1, 5, 0, 0, 1, 1, 9, 0, "R10");
        apply(1, 4, 9, 0, 1, 4, 10, 0, "R8");
        apply(1, 1, 9, 0, 1, 1, 10, 0, "R8");
        // R10: clear on port 1 refused while port 0 active, accepted when idle
        apply(1, 3, 11, 32'hBBBB_000B, 0, 0, 0, 0, "R10");
        apply(1, 1, 2, 0, 1, 5, 0, 0, "R10");
        apply(0, 0, 0, 0, 1, 4, 11, 0, "R10");
        apply(0, 0, 0, 0, 1, 5, 0, 0, "R10");
        apply(1, 4, 11, 0, 0, 0, 0, 0, "R10");
        // R12: unused op codes and idle
        apply(1, 6, 1, 0, 1, 7, 2, 0, "R12");
        apply(1, 0, 1, 0, 0, 4, 2, 0, "R12");

        // Mixed traffic in a narrow window to provoke collisions
        for (int i = 0; i < 600; i++) begin
            logic [2:0] o0, o1;
            o0 = 3'($urandom_range(0, 7));
            o1 = 3'($urandom_range(0, 7));
            if (o0 == 5 && ($urandom_range(0, 7) != 0)) o0 = 3;
            if (o1 == 5 && ($urandom_range(0, 7) != 0)) o1 = 4;
            apply($urandom_range(0, 3) != 0, o0, AW'($urandom_range(0, 3)), $urandom,
                  $urandom_range(0, 3) != 0, o1, AW'($urandom_range(0, 3)), $urandom, "R11");
        end

        idle("R12");
        @(posedge clk); @(negedge clk); #1;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule